// File: doc/BRIEF.md
# Delay Code Load-and-Hold Latch

This block sits in front of a programmable delay line and turns a set of select inputs into the code the line actually uses. It takes a ten-bit tap code plus one extra cascade bit, a load-enable and two override controls. While load-enable is low the block is transparent: the tap code and cascade bit flow straight through to the outputs in the same cycle. When load-enable goes high the present eleven bits are frozen in a holding register, and later changes on the select inputs are ignored until load-enable drops again.

Two overrides sit after the holding register. The minimum override forces every bit, including the cascade bit, to zero; the maximum override forces every bit to one and raises a flag that asks the delay line for one extra smallest step beyond the all-ones code. The minimum override beats the maximum override. Neither override touches the held contents, so releasing an override brings the held code back. The effective cascade bit leaves as a complementary pair so that a following stage can use it as its own override pair. The whole block is modelled synchronously; load-enable is sampled on the system clock to find its rising edge.

Top module: `dly_code_latch`

## Requirements
- R1: While load-enable is low and no override is active, `delayCode` equals `dataIn` and `cascadeOut` equals `cascadeIn` combinationally, in the same cycle.
- R2: The value frozen is the one on `dataIn`/`cascadeIn` at the first rising clock edge at which load-enable is sampled high; before that edge the outputs are still transparent, after it they show the frozen value and ignore any change of `dataIn`/`cascadeIn` until load-enable is low again.
- R3: With `setMin` high, `delayCode` is all zeros, the effective cascade bit is 0 and `forceMax` is 0, whatever the other inputs and whether transparent or holding.
- R4: With `setMax` high and `setMin` low, `delayCode` is all ones, the effective cascade bit is 1 and `forceMax` is 1.
- R5: With `setMin` and `setMax` both high, the minimum override wins: code all zeros, cascade bit 0, `forceMax` 0.
- R6: `cascadeOut` carries the effective cascade bit and `cascadeOutN` is always its complement (bit 0 gives `cascadeOut`=0, `cascadeOutN`=1).
- R7: The overrides do not change the held value; once both are released while load-enable is still high, the outputs show the code frozen before the override.
- R8: Reset (`rstN` low) clears the held value to zero; with load-enable high through and after reset, the outputs read code 0 and cascade bit 0 until load-enable has been low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| dataIn | input | 10 | Tap code select inputs |
| cascadeIn | input | 1 | Cascade select bit |
| loadEn | input | 1 | Low: transparent; rising: freeze; high: hold |
| setMin | input | 1 | Force minimum code (highest priority) |
| setMax | input | 1 | Force maximum code |
| delayCode | output | 10 | Effective tap code to the delay line |
| forceMax | output | 1 | Maximum override active (extra smallest step) |
| cascadeOut | output | 1 | Effective cascade bit |
| cascadeOutN | output | 1 | Complement of the effective cascade bit |

## Verification
The bench goes after the cycle in which load-enable rises: a design that froze one edge late or early would show a neighbouring data value instead of the one present at that edge, and one that lost transparency too soon would show stale held data in that cycle. It raises both overrides together, where a wrong priority would output all ones with the flag set, and releases an override while holding, where a design that wrote the forced value into the register would not bring back the frozen code. It also keeps load-enable high across reset, where a design that captured during reset would show the live inputs instead of zero.

// File: rtl/dly_code_pkg.sv
package dly_code_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic selHold;   // outputs come from the holding register, no capture
    logic forceMin;  // minimum override active
    logic forceMax;  // maximum override active (minimum not active)
  } dlyStrobe_t;

endpackage

// File: rtl/dly_code_ctrl.sv
module dly_code_ctrl
  import dly_code_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadEn,
  input  logic       setMin,
  input  logic       setMax,
  output dlyStrobe_t strb
);

  // Sampled load-enable; resets high so nothing is captured while
  // load-enable stays high through reset.
  logic loadEnQ;

  always_ff @(posedge clk) begin
    if (!rstN) loadEnQ <= 1'b1;
    else       loadEnQ <= loadEn;
  end

  // Holding starts once load-enable has been seen high at a clock edge
  // and is still high now.
  always_comb begin
    strb.selHold  = loadEn & loadEnQ;
    strb.forceMin = setMin;
    strb.forceMax = setMax & ~setMin;
  end

  // R2
  lock_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn && $past(loadEn)) |-> strb.selHold);

  // R5
  one_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.forceMin, strb.forceMax}));

endmodule

// File: rtl/dly_code_path.sv
module dly_code_path
  import dly_code_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  dlyStrobe_t        strb,
  input  logic [CODE_W-1:0] dataIn,
  input  logic              cascadeIn,
  output logic [CODE_W-1:0] delayCode,
  output logic              forceMax,
  output logic              cascadeOut,
  output logic              cascadeOutN
);

  localparam int FULL_W = CODE_W + 1;  // tap code plus cascade bit

  logic [FULL_W-1:0] liveIn;
  logic [FULL_W-1:0] heldCode;
  logic [FULL_W-1:0] passCode;
  logic [FULL_W-1:0] effCode;

  assign liveIn = {cascadeIn, dataIn};

  // Holding register tracks the inputs until the hold strobe is up.
  always_ff @(posedge clk) begin
    if (!rstN)              heldCode <= '0;
    else if (!strb.selHold) heldCode <= liveIn;
  end

  assign passCode = strb.selHold ? heldCode : liveIn;

  // Per-bit override cell: reset wins over set, both win over data.
  for (genvar b = 0; b < FULL_W; b++) begin : g_bit
    always_comb begin
      if (strb.forceMin)      effCode[b] = 1'b0;
      else if (strb.forceMax) effCode[b] = 1'b1;
      else                    effCode[b] = passCode[b];
    end
  end

  assign delayCode   = effCode[CODE_W-1:0];
  assign cascadeOut  = effCode[CODE_W];
  assign cascadeOutN = ~effCode[CODE_W];
  assign forceMax    = strb.forceMax;

  // R1
  transparent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.selHold && !strb.forceMin && !strb.forceMax)
      |-> ({cascadeOut, delayCode} == liveIn));

  // R3
  min_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.forceMin |-> (delayCode == '0 && !cascadeOut && !forceMax));

  // R6
  casc_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    cascadeOut != cascadeOutN);

  // R7
  held_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.selHold && $past(strb.selHold)) |-> (heldCode == $past(heldCode)));

endmodule

// File: rtl/dly_code_latch.sv
module dly_code_latch
  import dly_code_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] dataIn,
  input  logic              cascadeIn,
  input  logic              loadEn,
  input  logic              setMin,
  input  logic              setMax,
  output logic [CODE_W-1:0] delayCode,
  output logic              forceMax,
  output logic              cascadeOut,
  output logic              cascadeOutN
);

  dlyStrobe_t strb;

  dly_code_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .loadEn (loadEn),
    .setMin (setMin),
    .setMax (setMax),
    .strb   (strb)
  );

  dly_code_path #(.CODE_W(CODE_W)) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .dataIn      (dataIn),
    .cascadeIn   (cascadeIn),
    .delayCode   (delayCode),
    .forceMax    (forceMax),
    .cascadeOut  (cascadeOut),
    .cascadeOutN (cascadeOutN)
  );

endmodule

// File: tb/dly_code_latch_test.sv
`timescale 1ns/1ps
module dly_code_latch_test;

  logic       clk = 1'b0;
  logic       rstN;
  logic [9:0] dataIn;
  logic       cascadeIn;
  logic       loadEn;
  logic       setMin;
  logic       setMax;
  logic [9:0] delayCode;
  logic       forceMax;
  logic       cascadeOut;
  logic       cascadeOutN;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  dly_code_latch uut (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .cascadeIn(cascadeIn),
    .loadEn(loadEn), .setMin(setMin), .setMax(setMax),
    .delayCode(delayCode), .forceMax(forceMax),
    .cascadeOut(cascadeOut), .cascadeOutN(cascadeOutN)
  );

  // Vector: {loadEn, setMin, setMax, cascadeIn, dataIn[9:0],
  //          expCode[9:0], expCasc, expMax}
  localparam int NVEC = 13;
  localparam logic [25:0] VEC [NVEC] = '{
    {4'b0000, 10'h155, 10'h155, 1'b0, 1'b0},  // R1
    {4'b0001, 10'h2AA, 10'h2AA, 1'b1, 1'b0},  // R1 R6
    {4'b1000, 10'h0F0, 10'h0F0, 1'b0, 1'b0},  // R2 rise cycle
    {4'b1001, 10'h3FF, 10'h0F0, 1'b0, 1'b0},  // R2 held
    {4'b1100, 10'h3FF, 10'h000, 1'b0, 1'b0},  // R3
    {4'b1010, 10'h000, 10'h3FF, 1'b1, 1'b1},  // R4
    {4'b1110, 10'h3FF, 10'h000, 1'b0, 1'b0},  // R5
    {4'b1000, 10'h001, 10'h0F0, 1'b0, 1'b0},  // R7
    {4'b0001, 10'h001, 10'h001, 1'b1, 1'b0},  // R1
    {4'b0010, 10'h000, 10'h3FF, 1'b1, 1'b1},  // R4 transparent
    {4'b1001, 10'h123, 10'h123, 1'b1, 1'b0},  // R2 rise cycle
    {4'b1100, 10'h000, 10'h000, 1'b0, 1'b0},  // R3 held
    {4'b1000, 10'h200, 10'h123, 1'b1, 1'b0}   // R7 R6
  };

  task automatic chk(input string req, input logic [9:0] ec,
                     input logic eca, input logic emx);
    checks++;
    if (delayCode !== ec || cascadeOut !== eca || cascadeOutN !== ~eca ||
        forceMax !== emx) begin
      errors++;
      $display("FAIL %s: code=%h casc=%b cascN=%b max=%b expected code=%h casc=%b cascN=%b max=%b",
               req, delayCode, cascadeOut, cascadeOutN, forceMax,
               ec, eca, ~eca, emx);
    end
  endtask

  task automatic drive(input logic le, input logic mn, input logic mx,
                       input logic ci, input logic [9:0] d);
    @(negedge clk);
    loadEn = le; setMin = mn; setMax = mx; cascadeIn = ci; dataIn = d;
    #1;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R8: load-enable high through reset with live inputs all ones
    rstN = 1'b0; loadEn = 1'b1; setMin = 1'b0; setMax = 1'b0;
    cascadeIn = 1'b1; dataIn = 10'h3FF;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset", 10'h000, 1'b0, 1'b0);
    @(negedge clk); rstN = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk("R8 hold after reset", 10'h000, 1'b0, 1'b0);

    // R2: one-cycle low pulse captures the value at the rising edge
    drive(1'b0, 1'b0, 1'b0, 1'b1, 10'h0AB);
    chk("R1 pulse low", 10'h0AB, 1'b1, 1'b0);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 10'h0CD);
    chk("R2 rise cycle", 10'h0CD, 1'b0, 1'b0);
    drive(1'b1, 1'b0, 1'b0, 1'b1, 10'h3EE);
    chk("R2 frozen", 10'h0CD, 1'b0, 1'b0);

    // Back to transparent before the table
    drive(1'b0, 1'b0, 1'b0, 1'b0, 10'h000);
    for (int i = 0; i < NVEC; i++) begin
      logic [25:0] v;
      v = VEC[i];
      drive(v[25], v[24], v[23], v[22], v[21:12]);
      chk($sformatf("vector %0d (R1-style table, see comments)", i),
          v[11:2], v[1], v[0]);
    end

    // R7: override while holding for several edges, then release
    drive(1'b1, 1'b0, 1'b1, 1'b0, 10'h000);
    drive(1'b1, 1'b0, 1'b1, 1'b0, 10'h000);
    chk("R4 held override", 10'h3FF, 1'b1, 1'b1);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 10'h000);
    chk("R7 release restores", 10'h123, 1'b1, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule